// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers level interrupt lines from up to 31 peripherals and presents them to two target contexts, for example the machine and supervisor modes of one hart. Each source has a 3-bit urgency value. Each context has its own enable mask and its own priority threshold. A context's request line stays high while at least one source that it has enabled is pending with an urgency strictly above its threshold.

Software on a context handles an interrupt in three steps. It reads that context's claim register and receives the ID of the winning source. The read also moves the source from pending to in service. When the handler is done, software writes the same ID back to the same register. The source cannot raise a new request until that write arrives. ID 0 is reserved: a claim that returns 0 means that nothing is eligible.

All state is reached through a simple single-cycle 32-bit register bus with a sparse, fixed address map. A read returns its data in the cycle after the select.

Top module: `plic_core`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, both `irq_o` bits are low, and a claim read returns 0.
- R2: The priority of source n (1..31) sits at byte offset 4*n. Only bits [2:0] are stored, and the upper bits read 0. Offset 0, the slot for source 0, reads 0 and ignores writes.
- R3: The enable word of context c sits at offset 0x2000 + c*0x80. Bit n enables source n, and bit 0 always reads 0.
- R4: The threshold of context c sits at offset 0x200000 + c*0x1000 and stores bits [2:0]. The claim/complete register of context c sits at offset 0x200004 + c*0x1000. Bus address bits [1:0] are ignored.
- R5: `irq_o[c]` is high exactly when some source is pending, enabled for context c, and has a priority strictly greater than the threshold of context c. A threshold write takes effect in the cycle after the write.
- R6: A source with priority 0 never raises a request and is never returned by a claim.
- R7: A claim read returns, in the next cycle, the ID of the eligible source (as defined in R5) with the highest priority. On a tie the lowest ID wins, and with no eligible source the read returns 0.
- R8: A claim clears the pending bit of the claimed source. That source stays not pending until its ID is written to a claim/complete register. A write of an ID that is not in service (including 0) has no effect.
- R9: At each clock edge, a source that is neither pending nor in service takes its input level as its new pending bit. A pending bit ignores its input level until the source is claimed, so a level that falls after latching does not clear it.
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level_i | input | NSRC (31) | Level interrupt inputs; bit k is source k+1 |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW (24) | Byte offset into the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read select |
| irq_o | output | NCTX (2) | Request line per context |

## Verification
Two events can fall on the same clock edge: a source's level input rises, and a claim read or completion write touches that same source. The bench provokes this by changing the input levels in the same cycle as bus operations, in both directed and seeded random sequences. Two cases follow from this. A completion must not let the source re-latch in the completing cycle. A claim must pick only from pending bits that were already registered. A bench model that steps once per clock judges the outcome, by comparing every read value and both request lines in every cycle.

// File: rtl/plic_core_pkg.sv
package plic_core_pkg;

  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [11:0] THR_OFF    = 12'h000;
  localparam logic [11:0] CLM_OFF    = 12'h004;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_ENABLE,
    SEL_THRESH,
    SEL_CLAIM
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e   kind;
    logic [15:0] idx;
    logic [7:0]  ctx;
  } reg_sel_t;

  // Map a byte offset onto a register class, index and context.
  function automatic reg_sel_t decode_offset(input logic [31:0] byte_off,
                                             input int nsrc, input int nctx,
                                             input int nwords);
    reg_sel_t    r;
    logic [31:0] a;
    logic [31:0] rel;
    r.kind = SEL_NONE;
    r.idx  = '0;
    r.ctx  = '0;
    a      = {byte_off[31:2], 2'b00};
    rel    = '0;
    if (a < 32'(4 * (nsrc + 1))) begin
      if (a[31:2] != 30'd0) begin
        r.kind = SEL_PRIO;
        r.idx  = a[17:2];
      end
    end else if (a >= EN_BASE && a < EN_BASE + 32'(nctx) * EN_STRIDE) begin
      rel = a - EN_BASE;
      if (32'(rel[6:2]) < 32'(nwords)) begin
        r.kind = SEL_ENABLE;
        r.idx  = {11'd0, rel[6:2]};
        r.ctx  = rel[14:7];
      end
    end else if (a >= CTX_BASE && a < CTX_BASE + 32'(nctx) * CTX_STRIDE) begin
      rel   = a - CTX_BASE;
      r.ctx = rel[19:12];
      if (rel[11:0] == THR_OFF)      r.kind = SEL_THRESH;
      else if (rel[11:0] == CLM_OFF) r.kind = SEL_CLAIM;
    end
    return r;
  endfunction

  // A candidate displaces the current best only when strictly more urgent.
  function automatic logic prio_beats(input logic [7:0] cand, input logic [7:0] best);
    return cand > best;
  endfunction

endpackage

// File: rtl/plic_core_gateway.sv
module plic_core_gateway #(
  parameter int NSRC = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] level_i,
  input  logic [NSRC-1:0] take_i,
  input  logic [NSRC-1:0] done_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] held_o
);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic pend_nx;
    logic held_nx;

    always_comb begin
      if (pend_o[s]) pend_nx = ~take_i[s];
      else           pend_nx = level_i[s] & ~held_o[s];
      held_nx = (held_o[s] | take_i[s]) & ~done_i[s];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_o[s] <= 1'b0;
        held_o[s] <= 1'b0;
      end else begin
        pend_o[s] <= pend_nx;
        held_o[s] <= held_nx;
      end
    end
  end

endmodule

// File: rtl/plic_core_target.sv
module plic_core_target #(
  parameter int NSRC = 31,
  parameter int PW   = 3,
  parameter int IDW  = 5
) (
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC-1:0]    en_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [PW-1:0]      thr_i,
  output logic [IDW-1:0]     best_id_o,
  output logic [NSRC-1:0]    elig_o,
  output logic               irq_o
);
  import plic_core_pkg::*;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    assign elig_o[s] = pend_i[s] & en_i[s] & (prio_i[s*PW +: PW] > thr_i);
  end

  assign irq_o = |elig_o;

  // Ascending scan with strict compare: the lowest ID keeps a tie.
  always_comb begin
    logic [7:0] best_p;
    best_p    = 8'(thr_i);
    best_id_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (pend_i[s] && en_i[s] && prio_beats(8'(prio_i[s*PW +: PW]), best_p)) begin
        best_p    = 8'(prio_i[s*PW +: PW]);
        best_id_o = IDW'(s + 1);
      end
    end
  end

endmodule

// File: rtl/plic_core_regs.sv
module plic_core_regs #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PW     = 3,
  parameter int AW     = 24,
  parameter int IDW    = 5,
  parameter int NWORDS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NCTX*IDW-1:0] best_id_i,
  output logic [NSRC*PW-1:0] prio_o,
  output logic [NCTX*NSRC-1:0] en_o,
  output logic [NCTX*PW-1:0] thr_o,
  output logic [NSRC-1:0]    take_o,
  output logic [NSRC-1:0]    done_o,
  output logic               claim_fire_o,
  output logic [IDW-1:0]     claim_id_o,
  output logic               cmpl_fire_o,
  output logic [31:0]        cmpl_id_o
);
  import plic_core_pkg::*;

  reg_sel_t    rsel;
  logic        wr_ev;
  logic        rd_ev;
  logic [31:0] rd_val;

  assign rsel  = decode_offset(32'(addr_i), NSRC, NCTX, NWORDS);
  assign wr_ev = sel_i & we_i;
  assign rd_ev = sel_i & ~we_i;

  // Claim and completion events
  assign claim_fire_o = rd_ev && (rsel.kind == SEL_CLAIM);
  assign cmpl_fire_o  = wr_ev && (rsel.kind == SEL_CLAIM);
  assign cmpl_id_o    = wdata_i;

  always_comb begin
    claim_id_o = '0;
    if (claim_fire_o) claim_id_o = best_id_i[int'(rsel.ctx)*IDW +: IDW];
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_evt
    assign take_o[s] = claim_fire_o && (claim_id_o == IDW'(s + 1));
    assign done_o[s] = cmpl_fire_o && (wdata_i == 32'(s + 1));
  end

  // Priority storage
  for (genvar s = 0; s < NSRC; s++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n) prio_o[s*PW +: PW] <= '0;
      else if (wr_ev && rsel.kind == SEL_PRIO && rsel.idx == 16'(s + 1))
        prio_o[s*PW +: PW] <= wdata_i[PW-1:0];
    end
  end

  // Per-context enable bits and threshold
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    for (genvar s = 0; s < NSRC; s++) begin : g_en
      localparam int SRC_ID = s + 1;
      always_ff @(posedge clk) begin
        if (!rst_n) en_o[c*NSRC + s] <= 1'b0;
        else if (wr_ev && rsel.kind == SEL_ENABLE && rsel.ctx == 8'(c) &&
                 rsel.idx == 16'(SRC_ID / 32))
          en_o[c*NSRC + s] <= wdata_i[SRC_ID % 32];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) thr_o[c*PW +: PW] <= '0;
      else if (wr_ev && rsel.kind == SEL_THRESH && rsel.ctx == 8'(c))
        thr_o[c*PW +: PW] <= wdata_i[PW-1:0];
    end
  end

  // Read multiplexer
  always_comb begin
    rd_val = '0;
    case (rsel.kind)
      SEL_PRIO:   rd_val = 32'(prio_o[(int'(rsel.idx) - 1)*PW +: PW]);
      SEL_ENABLE: begin
        for (int s = 0; s < NSRC; s++) begin
          if ((s + 1) / 32 == int'(rsel.idx))
            rd_val[(s + 1) % 32] = en_o[int'(rsel.ctx)*NSRC + s];
        end
      end
      SEL_THRESH: rd_val = 32'(thr_o[int'(rsel.ctx)*PW +: PW]);
      SEL_CLAIM:  rd_val = 32'(best_id_i[int'(rsel.ctx)*IDW +: IDW]);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_ev) rdata_o <= rd_val;
  end

endmodule

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_level_i,
  input  logic            bus_sel_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic [NCTX-1:0] irq_o
);

  localparam int IDW    = $clog2(NSRC + 1);
  localparam int NWORDS = (NSRC + 32) / 32;

  logic [NSRC-1:0]      pend_w;
  logic [NSRC-1:0]      held_w;
  logic [NSRC-1:0]      take_w;
  logic [NSRC-1:0]      done_w;
  logic [NSRC*PW-1:0]   prio_w;
  logic [NCTX*NSRC-1:0] en_w;
  logic [NCTX*PW-1:0]   thr_w;
  logic [NCTX*IDW-1:0]  best_id_w;
  logic [NCTX*NSRC-1:0] elig_w;
  logic                 claim_fire_w;
  logic [IDW-1:0]       claim_id_w;
  logic                 cmpl_fire_w;
  logic [31:0]          cmpl_id_w;

  plic_core_gateway #(.NSRC(NSRC)) gw_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (src_level_i),
    .take_i  (take_w),
    .done_i  (done_w),
    .pend_o  (pend_w),
    .held_o  (held_w)
  );

  plic_core_regs #(
    .NSRC(NSRC), .NCTX(NCTX), .PW(PW), .AW(AW), .IDW(IDW), .NWORDS(NWORDS)
  ) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (bus_sel_i),
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .best_id_i    (best_id_w),
    .prio_o       (prio_w),
    .en_o         (en_w),
    .thr_o        (thr_w),
    .take_o       (take_w),
    .done_o       (done_w),
    .claim_fire_o (claim_fire_w),
    .claim_id_o   (claim_id_w),
    .cmpl_fire_o  (cmpl_fire_w),
    .cmpl_id_o    (cmpl_id_w)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_tgt
    plic_core_target #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) tgt_i (
      .pend_i    (pend_w),
      .en_i      (en_w[c*NSRC +: NSRC]),
      .prio_i    (prio_w),
      .thr_i     (thr_w[c*PW +: PW]),
      .best_id_o (best_id_w[c*IDW +: IDW]),
      .elig_o    (elig_w[c*NSRC +: NSRC]),
      .irq_o     (irq_o[c])
    );
  end

endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int IDW  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NSRC-1:0]     level,
  input logic [NSRC-1:0]     pend,
  input logic [NSRC-1:0]     held,
  input logic [NSRC*PW-1:0]  prio,
  input logic [NCTX*IDW-1:0] best_id,
  input logic [NCTX-1:0]     irq,
  input logic                claim_fire,
  input logic [IDW-1:0]      claim_id,
  input logic                cmpl_fire,
  input logic [31:0]         cmpl_id
);

  logic [NSRC-1:0] claim_mask;
  logic [NSRC-1:0] cmpl_mask;
  logic [NSRC-1:0] cand;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      claim_mask[s] = claim_fire && (claim_id == IDW'(s + 1));
      cmpl_mask[s]  = cmpl_fire && (cmpl_id == 32'(s + 1));
    end
  end
  assign cand = level & ~pend & ~held;

  // R8: a source is never pending and in service at once
  a_r8_pend_held_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & held) == '0);

  // R8: a claimed source goes into service and leaves pending
  a_r8_claim_moves_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|claim_mask) |=> (((held & $past(claim_mask)) == $past(claim_mask)) &&
                       ((pend & $past(claim_mask)) == '0)));

  // R8: completing an ID that is not in service leaves service state alone
  a_r8_stray_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire && ((cmpl_mask & held) == '0)) |=> $stable(held));

  // R9: an idle source with its level high becomes pending next edge
  a_r9_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |=> ((pend & $past(cand)) == $past(cand)));

  // R6: a claim never hands out a priority-0 source
  a_r6_no_zero_prio_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && claim_id != '0) |->
      (prio[(int'(claim_id) - 1)*PW +: PW] != '0));

  // R5/R7: the request line and the claim winner agree per context
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    a_r5_irq_vs_winner: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] == (best_id[c*IDW +: IDW] != '0));
  end

endmodule

bind plic_core plic_core_chk #(
  .NSRC(NSRC), .NCTX(NCTX), .PW(PW), .IDW(IDW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .level      (src_level_i),
  .pend       (pend_w),
  .held       (held_w),
  .prio       (prio_w),
  .best_id    (best_id_w),
  .irq        (irq_o),
  .claim_fire (claim_fire_w),
  .claim_id   (claim_id_w),
  .cmpl_fire  (cmpl_fire_w),
  .cmpl_id    (cmpl_id_w)
);

// File: tb/plic_core_tb_top.sv
module plic_core_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lvl_b = '0;
  logic        b_sel = 1'b0;
  logic        b_we = 1'b0;
  logic [23:0] b_addr = '0;
  logic [31:0] b_wd = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model, bit/index n = source n
  int          m_prio [32];
  logic [31:0] m_en   [2];
  int          m_thr  [2];
  logic [31:0] m_pend = '0;
  logic [31:0] m_held = '0;
  logic [31:0] m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plic_core dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_level_i (lvl_b[31:1]),
    .bus_sel_i   (b_sel),
    .bus_we_i    (b_we),
    .bus_addr_i  (b_addr),
    .bus_wdata_i (b_wd),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic int m_best(int c);
    int best = 0;
    int bp = m_thr[c];
    for (int n = 1; n < 32; n++)
      if (m_pend[n] && m_en[c][n] && m_prio[n] > bp) begin
        bp = m_prio[n];
        best = n;
      end
    return best;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (a < 128) return (a / 4 == 0) ? 32'd0 : 32'(m_prio[a / 4]);
    if (a >= 'h2000 && a < 'h2100)
      return ((a - 'h2000) % 128 < 4) ? (m_en[(a - 'h2000) / 128] & ~32'd1) : 32'd0;
    if (a >= 'h200000 && a < 'h202000) begin
      int c = (a - 'h200000) / 4096;
      int off = (a - 'h200000) % 4096;
      if (off == 0) return 32'(m_thr[c]);
      if (off == 4) return 32'(m_best(c));
    end
    return 32'd0;
  endfunction

  task automatic model_update();
    logic [31:0] take = '0;
    logic [31:0] done = '0;
    int a = int'({b_addr[23:2], 2'b00});
    if (b_sel && !b_we) begin
      m_rdata = exp_read(a);
      if (a >= 'h200000 && a < 'h202000 && (a - 'h200000) % 4096 == 4) begin
        int id = m_best((a - 'h200000) / 4096);
        if (id != 0) take[id] = 1'b1;
      end
    end
    if (b_sel && b_we) begin
      if (a < 128) begin
        if (a != 0) m_prio[a / 4] = int'(b_wd[2:0]);
      end else if (a >= 'h2000 && a < 'h2100) begin
        if ((a - 'h2000) % 128 < 4) m_en[(a - 'h2000) / 128] = b_wd;
      end else if (a >= 'h200000 && a < 'h202000) begin
        int c = (a - 'h200000) / 4096;
        int off = (a - 'h200000) % 4096;
        if (off == 0) m_thr[c] = int'(b_wd[2:0]);
        if (off == 4 && b_wd >= 1 && b_wd <= 31) done[b_wd[4:0]] = 1'b1;
      end
    end
    m_pend = ((m_pend & ~take) | (lvl_b & ~m_pend & ~m_held)) & ~32'd1;
    m_held = (m_held | take) & ~done;
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    b_sel = 1; b_we = 1; b_addr = 24'(a); b_wd = d;
    tick();
    b_sel = 0; b_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    b_sel = 1; b_we = 0; b_addr = 24'(a);
    tick();
    b_sel = 0;
    v = rdata;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed;
    for (int n = 0; n < 32; n++) m_prio[n] = 0;
    m_en[0] = '0; m_en[1] = '0; m_thr[0] = 0; m_thr[1] = 0;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1;

    // Reset state
    chk("R1 irq", 32'(irq), 0);
    rd('h14, v);     chk("R1 prio5", v, 0);
    rd('h200004, v); chk("R1 claim", v, 0);
    rd('h201000, v); chk("R1 thr1", v, 0);

    // Priority field and source 0
    wr('h14, 32'hFF); rd('h14, v); chk("R2 prio mask", v, 7);
    wr('h0, 32'h7);   rd('h0, v);  chk("R2 src0 prio", v, 0);

    // Enable layout
    wr('h2000, 32'hFFFF_FFFF); rd('h2000, v); chk("R3 en0 bit0", v, 32'hFFFF_FFFE);
    rd('h2080, v); chk("R3 en1 separate", v, 0);

    // Unmapped space
    wr('h3000, 32'h5); rd('h3000, v); chk("R10 unmapped", v, 0);
    wr('h200008, 32'h5); rd('h200008, v); chk("R10 ctx gap", v, 0);
    rd('h2004, v); chk("R10 en word1", v, 0);

    // Threshold strictness
    wr('h14, 3); wr('h24, 3); wr('h08, 1); wr('h1C, 0);
    lvl_b = (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 9);
    tick();
    wr('h200000, 3); chk("R5 thr equal blocks", 32'(irq[0]), 0);
    rd('h200000, v); chk("R4 thr read", v, 3);
    wr('h200000, 2); chk("R5 thr lower exposes", 32'(irq[0]), 1);
    chk("R3 ctx1 not enabled", 32'(irq[1]), 0);

    // Claim ordering
    rd('h200004, v); chk("R7 tie lowest id", v, 5);
    chk("R5 irq after claim", 32'(irq[0]), 1);
    lvl_b = '0;
    rd('h200004, v); chk("R7 second winner", v, 9);
    chk("R5 low prio held back", 32'(irq[0]), 0);
    wr('h200000, 0); chk("R5 thr zero", 32'(irq[0]), 1);
    rd('h200004, v); chk("R7 prio1 source", v, 2);
    rd('h200004, v); chk("R6 prio0 never claimed", v, 0);
    chk("R6 prio0 no irq", 32'(irq[0]), 0);

    // In-service gating and completion
    lvl_b = (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 9);
    tick();
    chk("R8 held sources stay quiet", 32'(irq[0]), 0);
    wr('h200004, 3); wr('h200004, 0); tick();
    chk("R8 stray complete ignored", 32'(irq[0]), 0);
    wr('h200004, 9); chk("R9 no latch in completing cycle", 32'(irq[0]), 0);
    tick(); chk("R9 relatch after complete", 32'(irq[0]), 1);
    lvl_b = '0; tick();
    chk("R9 level drop keeps pending", 32'(irq[0]), 1);
    rd('h200004, v); chk("R8 reclaim", v, 9);

    // Seeded random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom_range(0, 9));
      int c = int'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) lvl_b = $urandom() & ~32'd1;
      case (op)
        0: wr(4 * int'($urandom_range(0, 31)), $urandom());
        1: wr('h2000 + c * 'h80, $urandom());
        2: wr('h200000 + c * 'h1000, $urandom_range(0, 7));
        3, 4: begin rd('h200004 + c * 'h1000, v); chk("R7 random claim", v, m_rdata); end
        5: wr('h200004 + c * 'h1000, $urandom_range(0, 33));
        6: begin
          int n = int'($urandom_range(1, 31));
          if (m_held[n]) wr('h200004 + c * 'h1000, 32'(n)); else tick();
        end
        7: begin
          int sel = int'($urandom_range(0, 5));
          int a = (sel == 0) ? 4 * int'($urandom_range(0, 31)) :
                  (sel == 1) ? 'h2000 + c * 'h80 :
                  (sel == 2) ? 'h200000 + c * 'h1000 :
                  (sel == 3) ? 'h2004 + c * 'h80 :
                  (sel == 4) ? 'h200008 : 'h100;
          rd(a, v); chk("R10 random read", v, m_rdata);
        end
        default: tick();
      endcase
      chk("R5 random irq0", 32'(irq[0]), 32'(m_best(0) != 0));
      chk("R5 random irq1", 32'(irq[1]), 32'(m_best(1) != 0));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule